// File: doc/BRIEF.md
# Stride Value Predictor with Probabilistic Confidence

This block guesses the result an instruction will produce. It keeps, for each instruction address, the most recent result and the difference between its two most recent results. The next result is guessed as the most recent result plus that difference. A front-end stage presents an instruction address and gets back the guessed value and a flag that says whether the guess is trustworthy enough to use. When the instruction later commits, a second port presents the same address with the real result. The entry then learns the new difference and the new result.

Trust is held in a 3-bit counter per entry. A wrong guess clears the counter. A right guess raises it only when a pseudo-random draw succeeds, at a rate of 1/32 or 1/256 chosen by a mode pin. As a result, only instructions that stay predictable over a long run reach the saturated value, and only a saturated entry raises the use flag. The table is direct-mapped and holds 256 entries, each tagged with a slice of the address.

Top module: `stride_vpred`

## Requirements
- R1: After reset every entry is empty. No lookup hits and `lk_use` stays low until an update has filled the entry for that address.
- R2: The table index is address bits [9:2] and the tag is address bits [17:10]. When a valid lookup's tag matches, `lk_value` is the stored last result plus the stored difference, modulo 2^32. Otherwise `lk_value` is 0.
- R3: `lk_use` is high only when a valid lookup hits an entry whose counter is 7.
- R4: An update that hits, but whose actual result differs from the stored last result plus the stored difference, sets the counter to 0.
- R5: An update that hits with a correct guess raises the counter by one only when the random draw fires and the counter is below 7. Otherwise the counter keeps its value.
- R6: An update that hits stores a new difference equal to the actual result minus the stored last result, and then stores the actual result as the last result.
- R7: The random source is a 16-bit shift register. It loads 16'hACE1 in reset and steps on every clock after reset to {s[14:0], s[15]^s[13]^s[12]^s[10]}. An update's draw fires when the low 5 bits of the current state are all zero with `rare_mode`=0, or when the low 8 bits are all zero with `rare_mode`=1.
- R8: An update that misses, because the entry is empty or holds another tag, fills the entry with the new tag, last result equal to the actual result, difference 0 and counter 0.
- R9: When a lookup and an update fall in the same cycle, the lookup shows the contents from before the update. The update is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rare_mode | input | 1 | 0: raise counter with probability 1/32; 1: with probability 1/256 |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Lookup instruction address |
| lk_value | output | 32 | Guessed result (0 on miss) |
| lk_use | output | 1 | Guess is trusted (entry saturated) |
| up_valid | input | 1 | Commit update request |
| up_pc | input | 32 | Update instruction address |
| up_actual | input | 32 | Committed real result |

## Verification
A corrupted difference or last result shows up as a wrong `lk_value` on the very next lookup of that address. A counter that fails to clear after a wrong guess shows up as `lk_use` staying high on the following cycle. A counter that climbs too fast or too slowly moves the cycle in which `lk_use` first rises for a steady sequence. Because the bench steps its own copy of the random source, that shift is caught on the exact cycle, not only after many updates. A wrong tag slice or index slice makes two addresses that share an index either alias or miss, and this shows up in the lookup right after the conflicting update.

// File: rtl/svp_pkg.sv
package svp_pkg;
  localparam int VAL_W  = 32;
  localparam int TAG_W  = 8;
  localparam int CONF_W = 3;

  typedef logic [VAL_W-1:0]  val_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [CONF_W-1:0] conf_t;

  localparam conf_t CONF_MAX = '1;
  localparam conf_t CONF_ONE = conf_t'(1);

  typedef struct packed {
    tag_t  tag;
    val_t  last;
    val_t  stride;
    conf_t conf;
  } entry_t;

  // guessed next result
  function automatic val_t pred_sum(val_t last, val_t stride);
    return last + stride;
  endfunction

  // difference between the new result and the previous one
  function automatic val_t stride_of(val_t actual, val_t last);
    return actual - last;
  endfunction

  // counter step: clear on wrong guess or miss, rare climb on a right guess
  function automatic conf_t conf_next(conf_t c, logic hit, logic correct, logic fire);
    if (!hit || !correct) return '0;
    if (fire && (c != CONF_MAX)) return c + CONF_ONE;
    return c;
  endfunction
endpackage

// File: rtl/svp_lfsr.sv
module svp_lfsr #(
  parameter int          W       = 16,
  parameter logic [W-1:0] SEED   = 16'hACE1,
  parameter logic [W-1:0] TAPS   = 16'hB400,
  parameter int          LO_BITS = 5,
  parameter int          HI_BITS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rare_mode,
  output logic [W-1:0] state,
  output logic         fire
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= {state[W-2:0], fb};
  end

  assign fire = rare_mode ? (state[HI_BITS-1:0] == '0) : (state[LO_BITS-1:0] == '0);

  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n) state != '0)
    else $error("random source locked at zero");
endmodule

// File: rtl/svp_table.sv
module svp_table
  import svp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic             ra_vld,
  output entry_t           ra_ent,
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_vld,
  output entry_t           rb_ent,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  entry_t           w_ent
);
  localparam int DEPTH = 1 << IDX_W;

  entry_t           mem [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (we) vld[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[w_idx] <= w_ent;
  end

  assign ra_vld = vld[ra_idx];
  assign ra_ent = mem[ra_idx];
  assign rb_vld = vld[rb_idx];
  assign rb_ent = mem[rb_idx];
endmodule

// File: rtl/svp_update.sv
module svp_update
  import svp_pkg::*;
(
  input  logic   old_vld,
  input  entry_t old_ent,
  input  tag_t   new_tag,
  input  val_t   actual,
  input  logic   fire,
  output logic   hit,
  output logic   correct,
  output entry_t new_ent
);
  assign hit     = old_vld && (old_ent.tag == new_tag);
  assign correct = (actual == pred_sum(old_ent.last, old_ent.stride));

  always_comb begin
    new_ent.tag    = new_tag;
    new_ent.last   = actual;
    new_ent.stride = hit ? stride_of(actual, old_ent.last) : '0;
    new_ent.conf   = conf_next(old_ent.conf, hit, correct, fire);
  end
endmodule

// File: rtl/stride_vpred.sv
module stride_vpred
  import svp_pkg::*;
#(
  parameter int              PC_W      = 32,
  parameter int              IDX_W     = 8,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter int              LO_BITS   = 5,
  parameter int              HI_BITS   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rare_mode,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic [VAL_W-1:0] lk_value,
  output logic            lk_use,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic [VAL_W-1:0] up_actual
);
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;

  // address split
  logic [IDX_W-1:0] lk_idx, up_idx;
  tag_t             lk_tag, up_tag;
  assign lk_idx = lk_pc[TAG_LO-1:IDX_LO];
  assign lk_tag = lk_pc[TAG_LO+TAG_W-1:TAG_LO];
  assign up_idx = up_pc[TAG_LO-1:IDX_LO];
  assign up_tag = up_pc[TAG_LO+TAG_W-1:TAG_LO];

  // named internal events
  logic              lfsr_fire;
  logic [LFSR_W-1:0] lfsr_state;
  logic              lk_ent_vld, up_ent_vld;
  entry_t            lk_ent, up_old, up_new;
  logic              up_hit, up_correct, lk_hit;

  svp_lfsr #(
    .W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS),
    .LO_BITS(LO_BITS), .HI_BITS(HI_BITS)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rare_mode(rare_mode),
    .state(lfsr_state), .fire(lfsr_fire)
  );

  svp_table #(.IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(lk_idx), .ra_vld(lk_ent_vld), .ra_ent(lk_ent),
    .rb_idx(up_idx), .rb_vld(up_ent_vld), .rb_ent(up_old),
    .we(up_valid), .w_idx(up_idx), .w_ent(up_new)
  );

  svp_update u_update (
    .old_vld(up_ent_vld), .old_ent(up_old), .new_tag(up_tag),
    .actual(up_actual), .fire(lfsr_fire),
    .hit(up_hit), .correct(up_correct), .new_ent(up_new)
  );

  // lookup path: reads pre-update contents (R9)
  assign lk_hit   = lk_valid && lk_ent_vld && (lk_ent.tag == lk_tag);
  assign lk_value = lk_hit ? pred_sum(lk_ent.last, lk_ent.stride) : '0;
  assign lk_use   = lk_hit && (lk_ent.conf == CONF_MAX);

  // previous-update record for the checks below
  logic             p_v, p_hit, p_correct, p_fire;
  logic [IDX_W-1:0] p_idx;
  tag_t             p_tag;
  val_t             p_actual, p_last;
  conf_t            p_conf;
  logic             same_ent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_v <= 1'b0; p_hit <= 1'b0; p_correct <= 1'b0; p_fire <= 1'b0;
      p_idx <= '0; p_tag <= '0; p_actual <= '0; p_last <= '0; p_conf <= '0;
    end else begin
      p_v       <= up_valid;
      p_hit     <= up_hit;
      p_correct <= up_correct;
      p_fire    <= lfsr_fire;
      p_idx     <= up_idx;
      p_tag     <= up_tag;
      p_actual  <= up_actual;
      p_last    <= up_old.last;
      p_conf    <= up_old.conf;
    end
  end

  assign same_ent = p_v && up_valid && (up_idx == p_idx);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_use) else $error("use flag without lookup");

  assert_conf_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (same_ent && !(p_hit && p_correct)) |-> (up_old.conf == '0))
    else $error("counter not cleared after wrong guess or fill");

  assert_conf_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (same_ent && p_hit && p_correct) |->
      ((up_old.conf == p_conf) || (p_fire && (up_old.conf == p_conf + CONF_ONE))))
    else $error("counter moved without a draw");

  assert_learn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (same_ent && p_hit) |-> ((up_old.last == p_actual) && (up_old.stride == p_actual - p_last)))
    else $error("difference or last result not learned");

  assert_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (same_ent && !p_hit) |-> ((up_old.tag == p_tag) && (up_old.stride == '0) && (up_old.last == p_actual)))
    else $error("fill did not load a fresh entry");
endmodule

// File: tb/stride_vpred_tb.sv
`timescale 1ns/1ps
module stride_vpred_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rare_mode = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [31:0] lk_value;
  logic        lk_use;
  logic        up_valid = 1'b0;
  logic [31:0] up_pc = '0;
  logic [31:0] up_actual = '0;

  always #2 clk = ~clk;

  stride_vpred u_dut (
    .clk(clk), .rst_n(rst_n), .rare_mode(rare_mode),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_value(lk_value), .lk_use(lk_use),
    .up_valid(up_valid), .up_pc(up_pc), .up_actual(up_actual)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  bit          m_v [256];
  logic [7:0]  m_tag [256];
  logic [31:0] m_last [256];
  logic [31:0] m_str [256];
  int          m_conf [256];
  logic [15:0] m_lfsr;
  bit          use_seen;

  function automatic logic [7:0] idx_of(logic [31:0] pc);
    return pc[9:2];
  endfunction
  function automatic logic [7:0] tag_of(logic [31:0] pc);
    return pc[17:10];
  endfunction
  function automatic logic [15:0] lfsr_step(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
  function automatic bit draw(logic [15:0] s, logic mode);
    return mode ? (s[7:0] == 8'h00) : (s[4:0] == 5'h00);
  endfunction
  function automatic bit m_hit(logic [31:0] pc);
    return m_v[idx_of(pc)] && (m_tag[idx_of(pc)] == tag_of(pc));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_update(logic [31:0] pc, logic [31:0] act, logic mode);
    int i;
    i = idx_of(pc);
    if (m_hit(pc)) begin
      if (act != m_last[i] + m_str[i]) m_conf[i] = 0;
      else if (draw(m_lfsr, mode) && m_conf[i] < 7) m_conf[i] = m_conf[i] + 1;
      m_str[i]  = act - m_last[i];
      m_last[i] = act;
    end else begin
      m_v[i] = 1; m_tag[i] = tag_of(pc); m_last[i] = act; m_str[i] = '0; m_conf[i] = 0;
    end
  endtask

  // one cycle: drive at negedge, check lookup, step model at posedge
  task automatic tick(logic lv, logic [31:0] lpc, logic uv, logic [31:0] upc, logic [31:0] uact);
    logic [31:0] ev;
    logic        eu;
    lk_valid = lv; lk_pc = lpc; up_valid = uv; up_pc = upc; up_actual = uact;
    #1;
    ev = 0; eu = 0;
    if (lv && m_hit(lpc)) begin
      ev = m_last[idx_of(lpc)] + m_str[idx_of(lpc)];
      eu = (m_conf[idx_of(lpc)] == 7);
    end
    chk("R2/R9 lk_value", lk_value, ev);
    chk("R3/R4/R5/R7 lk_use", {31'b0, lk_use}, {31'b0, eu});
    if (lk_use) use_seen = 1;
    @(posedge clk);
    if (uv) model_update(upc, uact, rare_mode);
    m_lfsr = lfsr_step(m_lfsr);
    @(negedge clk);
  endtask

  // per-address generators for the random phase
  logic [31:0] g_pc [6];
  logic [31:0] g_val [6];
  logic [31:0] g_str [6];

  initial begin
    logic [31:0] pa, pb, pc3, v;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_last[i] = '0; m_str[i] = '0; m_conf[i] = 0;
    end
    m_lfsr = 16'hACE1;
    use_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty table after reset
    for (int k = 0; k < 4; k++) begin
      lk_valid = 1; lk_pc = 32'h0000_0040 * k + 32'h100; #1;
      chk("R1 reset value", lk_value, 32'h0);
      chk("R1 reset use", {31'b0, lk_use}, 32'h0);
      @(posedge clk); m_lfsr = lfsr_step(m_lfsr); @(negedge clk);
    end

    // R8/R6 literal checks on a fresh address
    pa = 32'h0000_1234;
    tick(0, 0, 1, pa, 32'd10);
    tick(1, pa, 0, 0, 0);
    chk("R8 fill last=actual stride=0", lk_value, 32'd10);
    tick(0, 0, 1, pa, 32'd17);
    tick(1, pa, 0, 0, 0);
    chk("R6 learned stride 7", lk_value, 32'd24);

    // steady stride with lookup of the same address each cycle (R5, R7 mode 0, R9)
    rare_mode = 1'b0;
    v = 32'd24;
    for (int k = 0; k < 700; k++) begin
      tick(1, pa, 1, pa, v);
      v = v + 32'd7;
    end
    chk("R3 saturation reached", {31'b0, use_seen}, 32'h1);

    // R4: a wrong guess clears the trust
    tick(1, pa, 1, pa, v + 32'd1);
    tick(1, pa, 0, 0, 0);
    chk("R4 use after wrong guess", {31'b0, lk_use}, 32'h0);

    // R8: same index, different tag
    pb = pa + 32'h0000_0400;
    tick(1, pb, 1, pb, 32'hDEAD_0000);
    tick(1, pa, 0, 0, 0);
    chk("R8 evicted address misses", lk_value, 32'h0);
    tick(1, pb, 0, 0, 0);
    chk("R8 new tag hits", lk_value, 32'hDEAD_0000);

    // R2: decreasing sequence across zero, rare mode (R7)
    rare_mode = 1'b1;
    pc3 = 32'h0003_0880;
    v = 32'd9;
    for (int k = 0; k < 300; k++) begin
      tick(1, pc3, 1, pc3, v);
      v = v - 32'd2;
    end
    tick(1, pc3, 0, 0, 0);
    chk("R2 wraparound guess", lk_value, v);

    // random phase
    for (int j = 0; j < 6; j++) begin
      g_pc[j]  = {14'h0, 2'(j % 3), 6'h0, 8'(j * 3), 2'b00};
      g_val[j] = $urandom;
      g_str[j] = (j == 5) ? 32'h0 : 32'($urandom_range(0, 20)) - 32'd10;
    end
    for (int k = 0; k < 20000; k++) begin
      int a, b;
      logic [31:0] act;
      if (k % 1000 == 0) rare_mode = $urandom_range(0, 1);
      a = $urandom_range(0, 5);
      b = $urandom_range(0, 5);
      g_val[a] = g_val[a] + g_str[a];
      act = ($urandom_range(0, 15) == 0) ? $urandom : g_val[a];
      tick($urandom_range(0, 3) != 0, g_pc[b], $urandom_range(0, 3) != 0, g_pc[a], act);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all requirements act=timeout exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule